// File: doc/BRIEF.md
# Option-Configured Reset Stretcher and Watchdog Enable

This block holds a one-byte nonvolatile configuration word and derives from it the power-up behaviour of the chip. Two of its bits choose how long the chip-wide active-low reset stays asserted after a power-on event and whether the watchdog starts running once that reset is released. A third bit drives a write-protect line for the main program memory. The remaining bits are kept and read back for use by neighbouring logic.

The configuration word can be rewritten only while the bootloader-mode flag is high. Neither power-on nor external reset changes its contents. The reset length and the watchdog choice are captured at the instant a reset event starts, so a rewrite during the stretch does not change the reset that is already running. While the wait-mode flag is high, the watchdog enable is gated by a dedicated configuration bit. It is released again as soon as wait mode ends.

Top module: `optreset_wdog`

## Requirements
- R1: The read value `optRdData` shows the stored byte with this layout: bit 6 memory protect, bit 4 short reset hold, bit 3 watchdog armed by reset, bit 2 watchdog allowed in wait mode, bits 1 and 0 general options. Bits 7 and 5 read as 0.
- R2: Bits 7 and 5 of a write are discarded. Writing 8'hFF in bootloader mode reads back as 8'h5F.
- R3: A write strobe `optWrEn` updates the byte at the same clock edge only when `bootMode` is high. With `bootMode` low the read value does not change.
- R4: Before any write the byte equals the `PRESET` parameter with bits 7 and 5 cleared. Power-on and external resets leave it unchanged.
- R5: A `porPulse` sampled at a clock edge drives `rstOutN` low for exactly 16 cycles when bit 4 was 1 and for 4064 cycles when it was 0. `rstOutN` is then high.
- R6: A `porPulse` that arrives while the stretch is running restarts the full period from that edge.
- R7: The hold length and the watchdog choice are taken from the byte as it stood at the reset edge. A write during the stretch does not alter the remaining count.
- R8: `extRstReq` sampled high at an edge drives `rstOutN` low for the following cycle. `rstOutN` returns high one cycle after the request is sampled low, provided no stretch is running.
- R9: After a power-on or external reset edge that saw bit 3 = 1 with `bootMode` low, `wdogEn` is high from the first cycle `rstOutN` is high. If bit 3 was 0, `wdogEn` stays low.
- R10: `wdogEn` is low whenever `bootMode` is high. A reset edge taken with `bootMode` high leaves the watchdog disarmed after bootloader mode ends.
- R11: While `waitMode` is high and bit 2 of the byte is 0, `wdogEn` is low. It returns in the cycle `waitMode` falls. With bit 2 = 1, wait mode has no effect.
- R12: `memWrProtect` equals bit 6 of the stored byte and follows an accepted write in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porPulse | input | 1 | Power-on event, high for one or more cycles |
| extRstReq | input | 1 | External reset request, active high |
| bootMode | input | 1 | Bootloader mode flag |
| waitMode | input | 1 | Wait (low-power) mode flag |
| optWrEn | input | 1 | Write strobe for the configuration byte |
| optWrData | input | 8 | Data for the configuration byte |
| rstOutN | output | 1 | Stretched chip reset, active low |
| wdogEn | output | 1 | Watchdog enable |
| memWrProtect | output | 1 | Program memory write protect |
| optRdData | output | 8 | Read value of the configuration byte |

## Verification
The stretch is measured for both settings of the hold-length bit. It is measured once from the preset value, giving the long hold, and once after a bootloader write, giving the short hold. This separates a wrong load value from a wrong bit selection. A second power-on pulse partway through the stretch and a write partway through it show apart a counter that restarts, one that ignores the pulse, and one that re-reads the live byte. The watchdog enable is exercised across external resets taken with bootloader mode high and low, and across wait mode with the wait bit clear and set. This separates gating by the latched arm state from gating by the live configuration bits.

// File: rtl/optreset_pkg.sv
package optreset_pkg;

  localparam int OPT_W       = 8;
  localparam int BIT_FACTORY = 7;
  localparam int BIT_PROTECT = 6;
  localparam int BIT_HOLE    = 5;
  localparam int BIT_RTIME   = 4;
  localparam int BIT_WDRST   = 3;
  localparam int BIT_WDWAIT  = 2;

  // Bits that exist in storage; the others always read as zero.
  localparam logic [OPT_W-1:0] KEEP_MASK =
    ~((OPT_W'(1) << BIT_FACTORY) | (OPT_W'(1) << BIT_HOLE));

  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic startHold;    // reload the stretch counter
    logic holdShort;    // length choice captured at the reload
    logic armUpdate;    // a reset event re-decides the watchdog arm state
    logic armValue;     // arm state to capture
    logic extActive;    // external reset request this cycle
    logic writeAccept;  // configuration byte takes the write data
  } ctlStrobes_t;

endpackage

// File: rtl/optreset_ctrl.sv
module optreset_ctrl
  import optreset_pkg::*;
(
  input  logic        porPulse,
  input  logic        extRstReq,
  input  logic        bootMode,
  input  logic        optWrEn,
  input  logic        cfgShortHold,
  input  logic        cfgWdAfterRst,
  output ctlStrobes_t strobes
);

  always_comb begin
    strobes             = '0;
    strobes.startHold   = porPulse;
    strobes.holdShort   = cfgShortHold;
    strobes.armUpdate   = porPulse | extRstReq;
    // Bootloader entry never arms the watchdog.
    strobes.armValue    = cfgWdAfterRst & ~bootMode;
    strobes.extActive   = extRstReq;
    strobes.writeAccept = optWrEn & bootMode;
  end

endmodule

// File: rtl/optreset_datapath.sv
module optreset_datapath
  import optreset_pkg::*;
#(
  parameter logic [7:0] PRESET     = 8'h00,
  parameter int         SHORT_HOLD = 16,
  parameter int         LONG_HOLD  = 4064
)(
  input  logic             clk,
  input  ctlStrobes_t      strobes,
  input  logic [OPT_W-1:0] optWrData,
  input  logic             bootMode,
  input  logic             waitMode,
  output logic             rstOutN,
  output logic             wdogEn,
  output logic             memWrProtect,
  output logic [OPT_W-1:0] optRdData,
  output logic             cfgShortHold,
  output logic             cfgWdAfterRst
);

  localparam int MAX_HOLD = (SHORT_HOLD > LONG_HOLD) ? SHORT_HOLD : LONG_HOLD;
  localparam int CNT_W    = $clog2(MAX_HOLD + 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_HOLD);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_HOLD);

  // Nonvolatile byte: only the preset gives it a value; no reset clears it.
  logic [OPT_W-1:0] nvByte = PRESET & KEEP_MASK;
  logic [CNT_W-1:0] holdCnt = '0;
  logic             extHold = 1'b0;
  logic             wdArmed = 1'b0;
  logic             waitBlock;

  always_ff @(posedge clk) begin
    if (strobes.writeAccept) nvByte <= optWrData & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (strobes.startHold)
      holdCnt <= strobes.holdShort ? SHORT_LOAD : LONG_LOAD;
    else if (holdCnt != '0)
      holdCnt <= holdCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    extHold <= strobes.extActive;
    if (strobes.armUpdate) wdArmed <= strobes.armValue;
  end

  assign cfgShortHold  = nvByte[BIT_RTIME];
  assign cfgWdAfterRst = nvByte[BIT_WDRST];
  assign optRdData     = nvByte & KEEP_MASK;
  assign memWrProtect  = nvByte[BIT_PROTECT];
  assign rstOutN       = (holdCnt == '0) & ~extHold;
  assign waitBlock     = waitMode & ~nvByte[BIT_WDWAIT];
  assign wdogEn        = wdArmed & rstOutN & ~bootMode & ~waitBlock;

  // R3: without an accepted write the byte keeps its value
  a_r3_byte_holds: assert property (@(posedge clk) disable iff (strobes.startHold)
    !strobes.writeAccept |=> $stable(nvByte));

  // R5: a running stretch counts down by one each cycle
  a_r5_count_down: assert property (@(posedge clk) disable iff (strobes.startHold)
    (holdCnt != '0) |=> (holdCnt == $past(holdCnt) - CNT_W'(1)));

  // R8: with no stretch and no request, reset is released the next cycle
  a_r8_ext_release: assert property (@(posedge clk) disable iff (strobes.startHold)
    (!strobes.extActive && holdCnt <= CNT_W'(1)) |=> rstOutN);

  // R12: protect output follows bit 6 of an accepted write
  a_r12_protect_follows: assert property (@(posedge clk) disable iff (strobes.startHold)
    strobes.writeAccept |=> (memWrProtect == $past(optWrData[BIT_PROTECT])));

endmodule

// File: rtl/optreset_wdog.sv
module optreset_wdog
  import optreset_pkg::*;
#(
  parameter logic [7:0] PRESET     = 8'h00,
  parameter int         SHORT_HOLD = 16,
  parameter int         LONG_HOLD  = 4064
)(
  input  logic       clk,
  input  logic       porPulse,
  input  logic       extRstReq,
  input  logic       bootMode,
  input  logic       waitMode,
  input  logic       optWrEn,
  input  logic [7:0] optWrData,
  output logic       rstOutN,
  output logic       wdogEn,
  output logic       memWrProtect,
  output logic [7:0] optRdData
);

  ctlStrobes_t strobes;
  logic        cfgShortHold;
  logic        cfgWdAfterRst;

  optreset_ctrl u_ctrl (
    .porPulse      (porPulse),
    .extRstReq     (extRstReq),
    .bootMode      (bootMode),
    .optWrEn       (optWrEn),
    .cfgShortHold  (cfgShortHold),
    .cfgWdAfterRst (cfgWdAfterRst),
    .strobes       (strobes)
  );

  optreset_datapath #(
    .PRESET     (PRESET),
    .SHORT_HOLD (SHORT_HOLD),
    .LONG_HOLD  (LONG_HOLD)
  ) u_dp (
    .clk           (clk),
    .strobes       (strobes),
    .optWrData     (optWrData),
    .bootMode      (bootMode),
    .waitMode      (waitMode),
    .rstOutN       (rstOutN),
    .wdogEn        (wdogEn),
    .memWrProtect  (memWrProtect),
    .optRdData     (optRdData),
    .cfgShortHold  (cfgShortHold),
    .cfgWdAfterRst (cfgWdAfterRst)
  );

  // R10: a reset edge taken in bootloader mode leaves the watchdog off
  a_r10_boot_no_arm: assert property (@(posedge clk) disable iff (porPulse)
    (bootMode && extRstReq) |=> !wdogEn);

endmodule

// File: tb/optreset_wdog_bench.sv
module optreset_wdog_bench;

  localparam logic [7:0] PRESET = 8'h00;

  logic clk = 1'b0;
  logic porPulse = 1'b0, extRstReq = 1'b0, bootMode = 1'b0, waitMode = 1'b0;
  logic optWrEn = 1'b0;
  logic [7:0] optWrData = 8'h00;
  logic rstOutN, wdogEn, memWrProtect;
  logic [7:0] optRdData;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  optreset_wdog #(.PRESET(PRESET)) u_optreset_wdog (
    .clk(clk), .porPulse(porPulse), .extRstReq(extRstReq), .bootMode(bootMode),
    .waitMode(waitMode), .optWrEn(optWrEn), .optWrData(optWrData),
    .rstOutN(rstOutN), .wdogEn(wdogEn), .memWrProtect(memWrProtect),
    .optRdData(optRdData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] mNv = PRESET & 8'h5F;
  int  mHold = 0;
  bit  mExt = 0;
  bit  mArm = 0;

  always @(posedge clk) begin
    logic [7:0] oldNv;
    oldNv = mNv;
    if (porPulse) mHold = oldNv[4] ? 16 : 4064;
    else if (mHold > 0) mHold--;
    if (porPulse || extRstReq) mArm = oldNv[3] && !bootMode;
    mExt = extRstReq;
    if (optWrEn && bootMode) mNv = optWrData & 8'h5F;
  end

  always @(negedge clk) begin
    bit expRst, expWd;
    expRst = (mHold == 0) && !mExt;
    expWd  = mArm && expRst && !bootMode && !(waitMode && !mNv[2]);
    chk("R5/R8 model rstOutN", int'(rstOutN), int'(expRst));
    chk("R9/R11 model wdogEn", int'(wdogEn), int'(expWd));
    chk("R12 model memWrProtect", int'(memWrProtect), int'(mNv[6]));
    chk("R1 model optRdData", int'(optRdData), int'(mNv));
  end

  task automatic pulse_por();
    @(posedge clk); #1 porPulse = 1'b1;
    @(posedge clk); #1 porPulse = 0;
  endtask

  task automatic write_byte(input logic boot, input logic [7:0] d);
    @(posedge clk); #1 bootMode = boot; optWrEn = 1'b1; optWrData = d;
    @(posedge clk); #1 bootMode = 1'b0; optWrEn = 1'b0;
  endtask

  task automatic measure_low(output int n);
    n = 0;
    @(negedge clk);
    while (!rstOutN && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    chk("R4 preset readback", int'(optRdData), int'(PRESET & 8'h5F));
    chk("R4 idle reset high", int'(rstOutN), 1);

    pulse_por(); measure_low(n);
    chk("R5 long hold length", n, 4064);
    chk("R9 watchdog off with bit3=0", int'(wdogEn), 0);

    write_byte(1'b0, 8'hFF); @(negedge clk);
    chk("R3 write outside boot ignored", int'(optRdData), int'(PRESET & 8'h5F));

    write_byte(1'b1, 8'hFF); @(negedge clk);
    chk("R2 bits 7 and 5 discarded", int'(optRdData), 'h5F);
    chk("R12 protect set", int'(memWrProtect), 1);

    pulse_por(); measure_low(n);
    chk("R5 short hold length", n, 16);
    chk("R9 watchdog armed by reset", int'(wdogEn), 1);

    pulse_por(); repeat (5) @(posedge clk);
    pulse_por(); measure_low(n);
    chk("R6 stretch restarted", n, 16);

    pulse_por();
    bootMode = 1'b1; optWrEn = 1'b1; optWrData = 8'h4B;
    @(posedge clk); #1 bootMode = 1'b0; optWrEn = 1'b0;
    measure_low(n);
    chk("R7 hold length latched at edge", n, 15);
    chk("R7 write during stretch stored", int'(optRdData), 'h4B);

    @(posedge clk); #1 extRstReq = 1'b1;
    @(negedge clk); chk("R8 not yet sampled", int'(rstOutN), 1);
    @(negedge clk); chk("R8 request asserts reset", int'(rstOutN), 0);
    @(posedge clk); @(posedge clk); #1 extRstReq = 1'b0;
    @(negedge clk); chk("R8 still low one cycle", int'(rstOutN), 0);
    @(negedge clk); chk("R8 released", int'(rstOutN), 1);
    chk("R9 armed after external reset", int'(wdogEn), 1);

    @(posedge clk); #1 waitMode = 1'b1;
    @(negedge clk); chk("R11 wait gates watchdog", int'(wdogEn), 0);
    @(posedge clk); #1 waitMode = 1'b0;
    @(negedge clk); chk("R11 restored after wait", int'(wdogEn), 1);
    write_byte(1'b1, 8'h4F);
    @(posedge clk); #1 waitMode = 1'b1;
    @(negedge clk); chk("R11 wait bit set keeps watchdog", int'(wdogEn), 1);
    @(posedge clk); #1 waitMode = 1'b0;

    @(posedge clk); #1 bootMode = 1'b1;
    @(negedge clk); chk("R10 boot mode gates watchdog", int'(wdogEn), 0);
    @(posedge clk); #1 extRstReq = 1'b1;
    @(posedge clk); #1 extRstReq = 1'b0;
    @(posedge clk); #1 bootMode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R10 reset in boot mode disarms", int'(wdogEn), 0);
    chk("R4 byte survives resets", int'(optRdData), 'h4F);

    @(posedge clk); #1 extRstReq = 1'b1;
    @(posedge clk); #1 extRstReq = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R9 rearmed outside boot", int'(wdogEn), 1);

    write_byte(1'b1, 8'h0F); @(negedge clk);
    chk("R12 protect cleared", int'(memWrProtect), 0);
    chk("R1 readback layout", int'(optRdData), 'h0F);

    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule